// File: doc/BRIEF.md
# Camera Byte Stream to RGB Video Stream Converter

This block sits at the head of a video pipeline, directly behind a CMOS image sensor with an 8-bit parallel output. It runs in the pixel-clock domain and watches the sensor's vertical sync, its line-valid strobe and its data byte. Two consecutive bytes form one RGB565 pixel. The block widens each colour field to 8 bits and sends the result as one 24-bit RGB888 beat on an AXI4-Stream Video master.

The stream has no sync or blanking signals, so the block adds the two sideband flags that locate every pixel. TUSER marks the first pixel after a frame start. TLAST marks the final pixel of each line. To set TLAST, the most recent pixel of a line is held back until the line-valid strobe falls.

A four-entry queue absorbs short stalls on TREADY. If the queue overflows, or a line ends with a byte that has no partner, a sticky error flag is raised. After an overflow, output is suppressed until the next frame begins, so no partial frame is resumed mid-line.

Top module: `cam_rgb_stream`

## Requirements
- R1: Each colour field is widened by appending its own most significant bits: red8 = {r5, r5[4:2]}, green8 = {g6, g6[5:4]}, blue8 = {b5, b5[4:2]}. `m_tdata` carries red in [23:16], green in [15:8] and blue in [7:0].
- R2: A byte is taken on a rising clock edge only while `href_i` is high. Bytes of a line pair up in arrival order, and each pair gives exactly one output pixel. The first byte of a pair carries {r5, g6[5:3]} and the second carries {g6[2:0], b5}.
- R3: `m_tuser` is high on the first pixel produced after a rising edge of `vsync_i` and low on every other pixel. A `vsync_i` rising edge also restarts byte pairing.
- R4: `m_tlast` is high on the last pixel of each line, which is the last pixel completed before `href_i` falls, and low on every other pixel.
- R5: Up to 4 pixels are buffered against backpressure without loss. While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tuser` and `m_tlast` hold their values.
- R6: If a line ends with an odd number of bytes, the unpaired byte produces no pixel and `err_o` is set.
- R7: A pixel that finds the buffer full sets `err_o`. That pixel and all later pixels are dropped until the first pixel of the next frame, which is accepted with `m_tuser` high. Pixels already buffered are still delivered.
- R8: After reset, `m_tvalid` and `err_o` are low. Once `err_o` is set it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sensor pixel clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_i | input | 1 | Sensor vertical sync; a rising edge starts a frame |
| href_i | input | 1 | Sensor line-valid; high while bytes of a line are presented |
| byte_i | input | 8 | Sensor data byte |
| m_tdata | output | 24 | RGB888 pixel |
| m_tvalid | output | 1 | Pixel beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tuser | output | 1 | Start-of-frame flag |
| m_tlast | output | 1 | End-of-line flag |
| err_o | output | 1 | Sticky error: buffer overflow or odd byte count |

## Verification
The assertions assume that `vsync_i` never rises while `href_i` is high. They also assume that `href_i` is low for at least one cycle between lines, so that a line end and a frame start never fall in the same cycle. The stimulus drives every line as a contiguous burst of bytes with `href_i` high. Each line is followed by several low cycles, and each frame start is a `vsync_i` pulse sent while `href_i` is low. Backpressure is applied in two ways: a toggling ready pattern that stays within the buffer depth, and a full stall long enough to force an overflow.

// File: rtl/cam_pkg.sv
package cam_pkg;
    localparam int BYTE_W = 8;
    localparam int R_W    = 5;
    localparam int G_W    = 6;
    localparam int B_W    = 5;
    localparam int CH_W   = 8;
    localparam int RGB_W  = 3 * CH_W;

    typedef struct packed {
        logic [RGB_W-1:0] rgb;
        logic             sof;
        logic             eol;
    } pix_t;
endpackage

// File: rtl/cam_field_widen.sv
module cam_field_widen #(
    parameter int IN_W  = 5,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  field_i,
    output logic [OUT_W-1:0] wide_o
);
    localparam int PAD_W = OUT_W - IN_W;

    // Replicating the top bits maps full-scale in to full-scale out.
    assign wide_o = {field_i, field_i[IN_W-1 -: PAD_W]};
endmodule

// File: rtl/cam_byte_pair.sv
module cam_byte_pair
    import cam_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              href_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              pix_vld_o,
    output pix_t              pix_o,
    output logic              odd_o
);
    typedef struct packed {
        logic              vs;
        logic              hr;
        logic              phase;
        logic [BYTE_W-1:0] hi;
        logic              hold_v;
        logic [RGB_W-1:0]  hold_rgb;
        logic              hold_sof;
        logic              arm;
        logic              ov;
        pix_t              op;
        logic              odd;
    } pair_st_t;

    pair_st_t st_q, st_d;

    logic [2*BYTE_W-1:0] word;
    logic [CH_W-1:0]     r8, g8, b8;

    assign word = {st_q.hi, byte_i};

    cam_field_widen #(.IN_W(R_W), .OUT_W(CH_W)) u_wr (
        .field_i (word[2*BYTE_W-1 -: R_W]),
        .wide_o  (r8)
    );
    cam_field_widen #(.IN_W(G_W), .OUT_W(CH_W)) u_wg (
        .field_i (word[B_W +: G_W]),
        .wide_o  (g8)
    );
    cam_field_widen #(.IN_W(B_W), .OUT_W(CH_W)) u_wb (
        .field_i (word[B_W-1:0]),
        .wide_o  (b8)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vs  = vsync_i;
        st_d.hr  = href_i;
        st_d.ov  = 1'b0;
        st_d.odd = 1'b0;
        if (href_i) begin
            if (!st_q.phase) begin
                st_d.hi    = byte_i;
                st_d.phase = 1'b1;
            end else begin
                st_d.phase = 1'b0;
                if (st_q.hold_v) begin
                    st_d.ov = 1'b1;
                    st_d.op = '{rgb: st_q.hold_rgb, sof: st_q.hold_sof, eol: 1'b0};
                end
                st_d.hold_v   = 1'b1;
                st_d.hold_rgb = {r8, g8, b8};
                st_d.hold_sof = st_q.arm;
                st_d.arm      = 1'b0;
            end
        end else if (st_q.hr) begin
            // Line end: the held pixel is the last one of the line.
            if (st_q.hold_v) begin
                st_d.ov = 1'b1;
                st_d.op = '{rgb: st_q.hold_rgb, sof: st_q.hold_sof, eol: 1'b1};
            end
            st_d.hold_v = 1'b0;
            st_d.odd    = st_q.phase;
            st_d.phase  = 1'b0;
        end
        if (vsync_i && !st_q.vs) begin
            st_d.phase  = 1'b0;
            st_d.arm    = 1'b1;
            st_d.hold_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_vld_o = st_q.ov;
    assign pix_o     = st_q.op;
    assign odd_o     = st_q.odd;

    // R2: a mid-line pixel leaves only after the second byte of its successor.
    a_r2_mid_emit: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ov && !st_q.op.eol |-> $past(href_i && st_q.phase));
    // R4: a flagged line-end pixel follows a falling line-valid.
    a_r4_eol_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ov && st_q.op.eol |-> $past(!href_i && st_q.hr));
    // R6: an odd report only follows a line end.
    a_r6_odd_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.odd |-> $past(!href_i && st_q.hr));
endmodule

// File: rtl/cam_pix_fifo.sv
module cam_pix_fifo
    import cam_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  pix_t wr_data,
    output logic full,
    input  logic rd_en,
    output pix_t rd_data,
    output logic empty
);
    // DEPTH must be a power of two so the pointers wrap naturally.
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] wr;
        logic [ADDR_W-1:0] rd;
        logic [CNT_W-1:0]  cnt;
    } ptr_st_t;

    ptr_st_t st_q, st_d;
    pix_t    mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.wr = st_q.wr + 1'b1;
        if (rd_en) st_d.rd = st_q.rd + 1'b1;
        case ({wr_en, rd_en})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[st_q.wr] <= wr_data;
    end

    assign full    = (st_q.cnt == CNT_W'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign rd_data = mem[st_q.rd];

    // R5: no write lands on a full buffer unless a slot frees in the same cycle.
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && full |-> rd_en);
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/cam_rgb_stream.sv
module cam_rgb_stream
    import cam_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              href_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [RGB_W-1:0]  m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tuser,
    output logic              m_tlast,
    output logic              err_o
);
    typedef struct packed {
        logic drop;
        logic err;
    } top_st_t;

    top_st_t st_q, st_d;

    logic pix_vld, odd, full, empty, pop, push, room, live;
    pix_t pix, head;

    cam_byte_pair u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync_i   (vsync_i),
        .href_i    (href_i),
        .byte_i    (byte_i),
        .pix_vld_o (pix_vld),
        .pix_o     (pix),
        .odd_o     (odd)
    );

    cam_pix_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_data (pix),
        .full    (full),
        .rd_en   (pop),
        .rd_data (head),
        .empty   (empty)
    );

    assign pop  = m_tvalid && m_tready;
    assign room = !full || pop;
    // A frame-start pixel ends a drop window.
    assign live = !st_q.drop || pix.sof;
    assign push = pix_vld && live && room;

    always_comb begin
        st_d = st_q;
        if (pix_vld && live) begin
            st_d.drop = !room;
        end
        if ((pix_vld && live && !room) || odd) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_tvalid = !empty;
    assign m_tdata  = head.rgb;
    assign m_tuser  = head.sof;
    assign m_tlast  = head.eol;
    assign err_o    = st_q.err;

    // R5: a stalled beat is held unchanged.
    a_r5_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata)
                                  && $stable(m_tuser) && $stable(m_tlast));
    // R8: the error flag is sticky.
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    // R7: while dropping, only a frame-start pixel may enter the buffer.
    a_r7_drop_gate: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.drop && push |-> pix.sof);
endmodule

// File: tb/cam_rgb_stream_bench.sv
module cam_rgb_stream_bench;
    typedef struct packed {
        logic [15:0] in565;
        logic [23:0] exp888;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{16'h0000, 24'h000000},
        '{16'hFFFF, 24'hFFFFFF},
        '{16'hF800, 24'hFF0000},
        '{16'h07E0, 24'h00FF00},
        '{16'h001F, 24'h0000FF},
        '{16'h8410, 24'h848284},
        '{16'h0841, 24'h080808},
        '{16'hA554, 24'hA5AAA5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsync_i = 1'b0;
    logic        href_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic [23:0] m_tdata;
    logic        m_tvalid, m_tuser, m_tlast, err_o;
    logic        m_tready = 1'b1;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int rdy_mode = 0;
    int rdy_cnt = 0;

    logic [23:0] cap_d [64];
    logic        cap_u [64];
    logic        cap_l [64];
    int          cap_n = 0;

    always #4 clk = ~clk;

    cam_rgb_stream u_cam_rgb_stream (
        .clk      (clk),
        .rst_n    (rst_n),
        .vsync_i  (vsync_i),
        .href_i   (href_i),
        .byte_i   (byte_i),
        .m_tdata  (m_tdata),
        .m_tvalid (m_tvalid),
        .m_tready (m_tready),
        .m_tuser  (m_tuser),
        .m_tlast  (m_tlast),
        .err_o    (err_o)
    );

    always @(negedge clk) begin
        rdy_cnt <= rdy_cnt + 1;
        case (rdy_mode)
            0:       m_tready <= 1'b1;
            1:       m_tready <= rdy_cnt[0];
            default: m_tready <= 1'b0;
        endcase
    end

    always @(negedge clk) begin
        #1;
        if (m_tvalid && m_tready && cap_n < 64) begin
            cap_d[cap_n] = m_tdata;
            cap_u[cap_n] = m_tuser;
            cap_l[cap_n] = m_tlast;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; vsync_i = 1'b0; href_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic frame_start();
        @(negedge clk); vsync_i = 1'b1;
        repeat (2) @(negedge clk);
        vsync_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_line(input int first, input int npix, input bit extra);
        for (int i = 0; i < npix; i++) begin
            @(negedge clk); href_i = 1'b1; byte_i = VEC[first + i].in565[15:8];
            @(negedge clk); byte_i = VEC[first + i].in565[7:0];
        end
        if (extra) begin
            @(negedge clk); href_i = 1'b1; byte_i = 8'h5A;
        end
        @(negedge clk); href_i = 1'b0; byte_i = 8'h00;
        repeat (6) @(negedge clk);
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
    endtask

    initial begin
        int base;
        do_reset();
        // R8: reset state
        check("R8 reset tvalid", 32'(m_tvalid), 32'd0);
        check("R8 reset err", 32'(err_o), 32'd0);

        // Vector table: one line of all entries, ready always high.
        base = cap_n;
        frame_start();
        send_line(0, NVEC, 1'b0);
        settle();
        check("R2 beat count", 32'(cap_n - base), 32'(NVEC));
        for (int i = 0; i < NVEC; i++) begin
            check("R1 widened data", 32'(cap_d[base + i]), 32'(VEC[i].exp888));
            check("R3 tuser", 32'(cap_u[base + i]), 32'(i == 0));
            check("R4 tlast", 32'(cap_l[base + i]), 32'(i == NVEC - 1));
        end

        // Second line, same frame, toggling ready.
        rdy_mode = 1;
        base = cap_n;
        send_line(4, 3, 1'b0);
        settle();
        rdy_mode = 0;
        check("R5 beat count under stall", 32'(cap_n - base), 32'd3);
        for (int i = 0; i < 3; i++) begin
            check("R5 data under stall", 32'(cap_d[base + i]), 32'(VEC[4 + i].exp888));
            check("R3 no tuser on later line", 32'(cap_u[base + i]), 32'd0);
            check("R4 tlast line 2", 32'(cap_l[base + i]), 32'(i == 2));
        end
        check("R5 no error", 32'(err_o), 32'd0);

        // Odd byte count.
        base = cap_n;
        send_line(1, 2, 1'b1);
        settle();
        check("R6 pixels from odd line", 32'(cap_n - base), 32'd2);
        check("R6 data 0", 32'(cap_d[base]), 32'(VEC[1].exp888));
        check("R6 tlast on last full pixel", 32'(cap_l[base + 1]), 32'd1);
        check("R6 error set", 32'(err_o), 32'd1);

        do_reset();
        check("R8 error cleared by reset", 32'(err_o), 32'd0);
        check("R8 tvalid after reset", 32'(m_tvalid), 32'd0);

        // Overflow: full stall during a line of 8.
        rdy_mode = 2;
        base = cap_n;
        frame_start();
        send_line(0, NVEC, 1'b0);
        settle();
        check("R7 error on overflow", 32'(err_o), 32'd1);
        rdy_mode = 0;
        settle();
        check("R7 buffered beats kept", 32'(cap_n - base), 32'd4);
        for (int i = 0; i < 4; i++) begin
            check("R7 kept data", 32'(cap_d[base + i]), 32'(VEC[i].exp888));
            check("R7 kept tlast", 32'(cap_l[base + i]), 32'd0);
        end
        base = cap_n;
        send_line(5, 2, 1'b0);
        settle();
        check("R7 dropped rest of frame", 32'(cap_n - base), 32'd0);
        base = cap_n;
        frame_start();
        send_line(2, 2, 1'b0);
        settle();
        check("R7 resume count", 32'(cap_n - base), 32'd2);
        check("R7 resume tuser", 32'(cap_u[base]), 32'd1);
        check("R7 resume data", 32'(cap_d[base + 1]), 32'(VEC[3].exp888));
        check("R4 resume tlast", 32'(cap_l[base + 1]), 32'd1);
        check("R8 error sticky", 32'(err_o), 32'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog expired act=0 exp=1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule